// File: doc/BRIEF.md
# Shadow-Memory Nonvolatile Transfer Controller

This block decides when a static RAM array with a nonvolatile shadow copies its whole contents into the shadow (a store) and when it copies the shadow back into the RAM (a recall). A store can be asked for in three ways. The first is a level request on a shared open-drain line. The second is a software command pulse. The third is a supply-good comparator reporting that the supply has dropped. A recall is started by a software command, or automatically when the supply comes back.

The controller gates the RAM read and write enables. It pulls the shared busy line while a store runs. It marks the start and direction of each transfer with a one-cycle go pulse to a modelled copy engine. A "written since the last transfer" flag decides whether a line request or a power-fail request does any work. Store, recall and the grace interval after a line request are fixed clock-cycle counts set by parameters.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: While `rst_n` is low, `rd_en`, `wr_en`, `busy_pull` and `nv_go` are all 0. The controller leaves reset in the powered-down state with auto-store enabled and the written flag clear.
- R2: In the powered-down state, a high `supply_ok` starts a recall. `nv_go` pulses with `nv_dir` = 0 (0 means recall, 1 means store), and the recall lasts RECALL_CYCLES cycles.
- R3: With the supply good, no transfer running and `hw_req_n` high, `rd_en` follows `rd_req` and `wr_en` follows `wr_req` in the same cycle.
- R4: During every store and recall, `rd_en` and `wr_en` are both 0.
- R5: `busy_pull` is 1 for exactly STORE_CYCLES cycles for each store, whatever started it. It stays 0 during recalls.
- R6: When `hw_req_n` is sampled low, the controller waits GRACE_CYCLES cycles. It then starts a store only if the written flag is set; otherwise it does nothing. So `busy_pull` first reads 1 at the GRACE_CYCLES+1-th falling clock edge after the line drops. A line held low asks for only one store.
- R7: During the grace interval reads still pass. A write that was granted in the cycle before `hw_req_n` fell keeps `wr_en` while `wr_req` is held. Any write that starts while `hw_req_n` is low is refused until the line is high again.
- R8: `sw_store` starts a store one cycle later whether or not anything was written. If `sw_store` and `sw_recall` arrive in the same cycle, the store wins.
- R9: While `supply_ok` is low, `rd_en` and `wr_en` are 0. A supply drop with auto-store enabled and the written flag set starts a store. With the flag clear, no store takes place.
- R10: `sw_auto_off` disables the power-fail store and `sw_auto_on` enables it again. While it is disabled, a supply drop starts no store even when the array is written.
- R11: The written flag is set by every cycle with `wr_en` = 1. It is cleared when any store or recall completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply comparator, 1 = above switch threshold |
| hw_req_n | input | 1 | Sensed level of the shared request line, 0 = store requested |
| sw_store | input | 1 | Software store command pulse |
| sw_recall | input | 1 | Software recall command pulse |
| sw_auto_off | input | 1 | Disable power-fail store |
| sw_auto_on | input | 1 | Enable power-fail store |
| rd_req | input | 1 | RAM read request |
| wr_req | input | 1 | RAM write request (held for a multi-cycle write) |
| rd_en | output | 1 | Gated RAM read enable |
| wr_en | output | 1 | Gated RAM write enable |
| busy_pull | output | 1 | 1 = pull the shared busy line low (store running) |
| nv_go | output | 1 | One-cycle start pulse to the copy engine |
| nv_dir | output | 1 | Transfer direction, 1 = store, 0 = recall |

## Verification
The store decision is exercised with each trigger, once with the array clean and once after a write. This shows that the written flag gates only the line and power-fail paths, while the software path ignores it. The line request is driven with three write patterns: a write already under way, a new write during the grace window, and a write after the line rises. These separate the in-flight grant from refusal. Simultaneous software commands, the auto-store toggle, and a recall followed by a line request each check priority, the mode flag, and clearing of the flag by a recall.

// File: rtl/nvs_pkg.sv
// Package: shared state encoding for the nonvolatile transfer controller.
// Assumes: nothing beyond the enum below.
package nvs_pkg;

    typedef enum logic [2:0] {
        NVS_OFF    = 3'd0,  // supply below threshold, array inaccessible
        NVS_RUN    = 3'd1,  // normal RAM access
        NVS_GRACE  = 3'd2,  // line request seen, in-flight access finishing
        NVS_STORE  = 3'd3,  // array -> shadow copy
        NVS_RECALL = 3'd4   // shadow -> array copy
    } nvs_state_t;

    // True for the two states in which the copy engine runs.
    function automatic logic nvs_is_xfer(input nvs_state_t s);
        return (s == NVS_STORE) || (s == NVS_RECALL);
    endfunction

endpackage

// File: rtl/nvs_cycle_timer.sv
// Module: down-counter that times one controller state.
// Assumes: load_val >= 1. After a load of N, the counter holds N, N-1 .. 1,
// so 'last' is high in the N-th cycle after the load edge. Once at 1 it holds.
module nvs_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Count down toward 1, or reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(1);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/nvs_dirty_track.sv
// Module: keeps the "written since last transfer" flag.
// Assumes: a set and a clear never arrive in the same cycle, because writes
// are blocked during transfers. The clear is still given priority.
module nvs_dirty_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,    // a write was granted this cycle
    input  logic xfer_done,  // a store or recall finishes this cycle
    output logic dirty_now   // flag including this cycle's write
);

    logic dirty_q;

    // Set on granted writes, clear on transfer completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (xfer_done) begin
            dirty_q <= 1'b0;
        end else if (wr_fire) begin
            dirty_q <= 1'b1;
        end
    end

    assign dirty_now = dirty_q | wr_fire;

endmodule

// File: rtl/nvs_access_gate.sv
// Module: gates RAM read and write enables from controller state and request line.
// Assumes: a write is a level request held for as many cycles as it needs.
// A write counts as in flight if it was granted in the previous cycle.
module nvs_access_gate
    import nvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  nvs_state_t state,
    input  logic       supply_ok,
    input  logic       hw_req_n,
    input  logic       rd_req,
    input  logic       wr_req,
    output logic       rd_en,
    output logic       wr_en
);

    logic open_q;   // previous cycle's write was granted
    logic access_ok;
    logic wr_allow;

    // Access is only possible with good supply in the normal or grace state.
    always_comb begin
        access_ok = supply_ok && ((state == NVS_RUN) || (state == NVS_GRACE));
    end

    // With the line low, only a write already under way may continue.
    always_comb begin
        wr_allow = hw_req_n || open_q;
    end

    assign rd_en = rd_req && access_ok;
    assign wr_en = wr_req && access_ok && wr_allow;

    // Remember whether a write is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= wr_en;
        end
    end

endmodule

// File: rtl/nvs_seq.sv
// Module: state sequencer that chooses between store, recall, grace and idle.
// Assumes: the cycle counts fit in CW bits and are at least 1. Command pulses
// are accepted only in the normal state. The mode commands are accepted at any time.
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int CW            = 4,
    parameter int GRACE_CYCLES  = 4,
    parameter int STORE_CYCLES  = 6,
    parameter int RECALL_CYCLES = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          hw_req_n,
    input  logic          sw_store,
    input  logic          sw_recall,
    input  logic          sw_auto_off,
    input  logic          sw_auto_on,
    input  logic          dirty_now,
    input  logic          tmr_last,
    output nvs_state_t    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          xfer_done,
    output logic          nv_go,
    output logic          nv_dir,
    output logic          busy_pull
);

    localparam logic [CW-1:0] GRACE_LD  = CW'(GRACE_CYCLES);
    localparam logic [CW-1:0] STORE_LD  = CW'(STORE_CYCLES);
    localparam logic [CW-1:0] RECALL_LD = CW'(RECALL_CYCLES);

    nvs_state_t state_q, state_d;
    logic       auto_q;     // power-fail store enabled
    logic       arm_q;      // line has been high since the last line request
    logic       go_q, dir_q;
    logic       pf_store;   // power-fail store would do work
    logic       entering;   // a transition into a timed state

    // Power-fail store needs the mode enabled and something written.
    always_comb begin
        pf_store = auto_q && dirty_now;
    end

    // Next-state choice, in priority order for the normal state.
    always_comb begin
        state_d   = state_q;
        xfer_done = 1'b0;
        unique case (state_q)
            NVS_OFF: begin
                if (supply_ok) state_d = NVS_RECALL;
            end
            NVS_RUN: begin
                if (!supply_ok)                state_d = pf_store ? NVS_STORE : NVS_OFF;
                else if (sw_store)             state_d = NVS_STORE;
                else if (sw_recall)            state_d = NVS_RECALL;
                else if (!hw_req_n && arm_q)   state_d = NVS_GRACE;
            end
            NVS_GRACE: begin
                if (!supply_ok)                state_d = pf_store ? NVS_STORE : NVS_OFF;
                else if (tmr_last)             state_d = dirty_now ? NVS_STORE : NVS_RUN;
            end
            NVS_STORE, NVS_RECALL: begin
                if (tmr_last) begin
                    xfer_done = 1'b1;
                    state_d   = supply_ok ? NVS_RUN : NVS_OFF;
                end
            end
            default: state_d = NVS_OFF;
        endcase
    end

    // Load the timer with the length of the state being entered.
    always_comb begin
        entering = (state_d != state_q);
        tmr_load = 1'b0;
        tmr_val  = GRACE_LD;
        if (entering) begin
            unique case (state_d)
                NVS_GRACE:  begin tmr_load = 1'b1; tmr_val = GRACE_LD;  end
                NVS_STORE:  begin tmr_load = 1'b1; tmr_val = STORE_LD;  end
                NVS_RECALL: begin tmr_load = 1'b1; tmr_val = RECALL_LD; end
                default:    begin tmr_load = 1'b0; tmr_val = GRACE_LD;  end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NVS_OFF;
        else        state_q <= state_d;
    end

    // Auto-store mode flag, disable wins over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)           auto_q <= 1'b1;
        else if (sw_auto_off) auto_q <= 1'b0;
        else if (sw_auto_on)  auto_q <= 1'b1;
    end

    // One line request per low period: re-armed only by a high line.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       arm_q <= 1'b0;
        else if (hw_req_n)                                arm_q <= 1'b1;
        else if (state_q == NVS_RUN && state_d == NVS_GRACE) arm_q <= 1'b0;
    end

    // Start pulse and direction for the copy engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            go_q <= entering && nvs_is_xfer(state_d);
            if (entering && nvs_is_xfer(state_d)) dir_q <= (state_d == NVS_STORE);
        end
    end

    assign state     = state_q;
    assign nv_go     = go_q;
    assign nv_dir    = dir_q;
    assign busy_pull = (state_q == NVS_STORE);

endmodule

// File: rtl/nv_shadow_ctrl.sv
// Module: top of the nonvolatile store/recall controller.
// Assumes: all inputs are synchronous to clk. hw_req_n is the sensed level of
// the shared line, and busy_pull drives that line's open-drain pull-down.
module nv_shadow_ctrl
    import nvs_pkg::*;
#(
    parameter int GRACE_CYCLES  = 4,
    parameter int STORE_CYCLES  = 6,
    parameter int RECALL_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic hw_req_n,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sw_auto_off,
    input  logic sw_auto_on,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_en,
    output logic wr_en,
    output logic busy_pull,
    output logic nv_go,
    output logic nv_dir
);

    localparam int MAX_AB = (GRACE_CYCLES > STORE_CYCLES) ? GRACE_CYCLES : STORE_CYCLES;
    localparam int MAX_C  = (MAX_AB > RECALL_CYCLES) ? MAX_AB : RECALL_CYCLES;
    localparam int CW     = $clog2(MAX_C + 1);

    nvs_state_t    state;
    logic          tmr_load, tmr_last, xfer_done, dirty_now;
    logic [CW-1:0] tmr_val;

    nvs_seq #(
        .CW(CW), .GRACE_CYCLES(GRACE_CYCLES),
        .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_req_n(hw_req_n),
        .sw_store(sw_store), .sw_recall(sw_recall),
        .sw_auto_off(sw_auto_off), .sw_auto_on(sw_auto_on),
        .dirty_now(dirty_now), .tmr_last(tmr_last), .state(state),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .xfer_done(xfer_done),
        .nv_go(nv_go), .nv_dir(nv_dir), .busy_pull(busy_pull)
    );

    nvs_cycle_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    nvs_dirty_track u_dirty (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_en), .xfer_done(xfer_done), .dirty_now(dirty_now)
    );

    nvs_access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .state(state), .supply_ok(supply_ok), .hw_req_n(hw_req_n),
        .rd_req(rd_req), .wr_req(wr_req), .rd_en(rd_en), .wr_en(wr_en)
    );

endmodule

// File: rtl/nvs_ctrl_chk.sv
// Module: property checker for nv_shadow_ctrl, attached with bind.
// Assumes: port names match the top module's signals.
module nvs_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic hw_req_n,
    input logic rd_en,
    input logic wr_en,
    input logic busy_pull,
    input logic nv_go,
    input logic nv_dir
);

    // R4: no RAM access while the store holds the busy line.
    a_r4_no_access_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull |-> (!rd_en && !wr_en));

    // R4: no RAM access in the first cycle of any transfer.
    a_r4_no_access_at_go: assert property (@(posedge clk) disable iff (!rst_n)
        nv_go |-> (!rd_en && !wr_en));

    // R5: the busy line is never pulled during a recall.
    a_r5_quiet_recall: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_go && !nv_dir) |-> !busy_pull);

    // R5: the busy line only rises together with a store start.
    a_r5_busy_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_pull) |-> (nv_go && nv_dir));

    // R7: a write not already granted is refused while the line is low.
    a_r7_new_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_req_n && !$past(wr_en)) |-> !wr_en);

    // R9: no access while the supply is low.
    a_r9_no_access_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!rd_en && !wr_en));

    // R2: the start pulse lasts one cycle.
    a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        nv_go |=> !nv_go);

endmodule

bind nv_shadow_ctrl nvs_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_req_n(hw_req_n),
    .rd_en(rd_en), .wr_en(wr_en), .busy_pull(busy_pull), .nv_go(nv_go), .nv_dir(nv_dir)
);

// File: tb/tb_nv_shadow_ctrl.sv
module tb_nv_shadow_ctrl;

    localparam int GC = 4;
    localparam int SC = 6;
    localparam int RC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1, hw_req_n = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, sw_auto_off = 1'b0, sw_auto_on = 1'b0;
    logic rd_req = 1'b1, wr_req = 1'b0;
    logic rd_en, wr_en, busy_pull, nv_go, nv_dir;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nv_shadow_ctrl #(.GRACE_CYCLES(GC), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hw_req_n(hw_req_n),
        .sw_store(sw_store), .sw_recall(sw_recall), .sw_auto_off(sw_auto_off),
        .sw_auto_on(sw_auto_on), .rd_req(rd_req), .wr_req(wr_req),
        .rd_en(rd_en), .wr_en(wr_en), .busy_pull(busy_pull), .nv_go(nv_go), .nv_dir(nv_dir)
    );

    // Table for R3: {rd_req, wr_req, expected rd_en, expected wr_en}.
    localparam logic [3:0] VEC [4] = '{4'b0000, 4'b1010, 4'b0101, 4'b1111};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Look for a start pulse at this and up to lim following falling edges.
    task automatic wait_go(input int lim, output bit found, output int lat);
        found = 0; lat = -1;
        for (int i = 0; i <= lim; i++) begin
            if (nv_go) begin found = 1; lat = i; break; end
            @(negedge clk);
        end
    endtask

    // Count the cycles of a running transfer: busy for a store, blocked reads for a recall.
    task automatic count_xfer(input bit is_store, output int n);
        n = 0;
        while ((is_store ? busy_pull : !rd_en) && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_write();
        wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_store(input string req);
        bit f; int lat, n;
        wait_go(3, f, lat);
        chk(f && nv_dir, req, {f, nv_dir}, 3);
        count_xfer(1, n);
        chk(n == SC, "R5 store length", n, SC);
    endtask

    task automatic expect_recall(input string req);
        bit f; int lat, n;
        wait_go(3, f, lat);
        chk(f && !nv_dir && !busy_pull, req, {f, nv_dir, busy_pull}, 4);
        count_xfer(0, n);
        chk(n == RC, "R2 recall length", n, RC);
    endtask

    // Watch a window with no transfer expected.
    task automatic expect_none(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (nv_go || busy_pull) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt; bit hit;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!rd_en && !wr_en && !busy_pull && !nv_go, "R1 reset outputs",
            {rd_en, wr_en, busy_pull, nv_go}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_recall("R2 power-up recall");

        // R3: table of pass-through patterns
        foreach (VEC[i]) begin
            rd_req = VEC[i][3]; wr_req = VEC[i][2];
            #1;
            chk({rd_en, wr_en} == VEC[i][1:0], "R3 gate table", {rd_en, wr_en}, VEC[i][1:0]);
            @(negedge clk);
        end
        wr_req = 1'b0; rd_req = 1'b1;
        @(negedge clk);

        // R8: software store after writes; leaves array clean
        sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
        expect_store("R8 sw store dirty");

        // R6/R7: line request while clean: reads pass, new write refused, no store
        hw_req_n = 1'b0; wr_req = 1'b1;
        #1;
        chk(rd_en && !wr_en, "R7 new write refused, read passes", {rd_en, wr_en}, 2);
        expect_none(GC + 8, "R6 clean line request skipped");
        chk(!wr_en, "R7 write still refused after grace", wr_en, 0);
        hw_req_n = 1'b1;
        #1;
        chk(wr_en, "R7 write accepted after line high", wr_en, 1);
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);

        // R6/R7: in-flight write across the line drop, then a store after grace
        wr_req = 1'b1; @(negedge clk);
        hw_req_n = 1'b0;
        #1;
        chk(wr_en, "R7 in-flight write continues", wr_en, 1);
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
        wr_req = 1'b1;
        #1;
        chk(!wr_en && rd_en, "R7 restart in grace refused", {rd_en, wr_en}, 2);
        wr_req = 1'b0;
        cnt = 2;
        while (!busy_pull && cnt < 40) begin @(negedge clk); cnt++; end
        chk(cnt == GC + 1, "R6 store after grace", cnt, GC + 1);
        count_xfer(1, cnt);
        chk(cnt == SC, "R5 line store length", cnt, SC);
        expect_none(GC + 4, "R6 held line gives one store");
        hw_req_n = 1'b1;
        @(negedge clk);

        // R8: clean software store still runs; store beats recall
        sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
        expect_store("R8 sw store clean");
        sw_store = 1'b1; sw_recall = 1'b1; @(negedge clk); sw_store = 1'b0; sw_recall = 1'b0;
        expect_store("R8 store wins over recall");
        sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
        expect_recall("R5 sw recall, busy quiet");

        // R9: power-fail store when written
        do_write();
        supply_ok = 1'b0;
        #1;
        chk(!rd_en, "R9 read blocked on low supply", rd_en, 0);
        @(negedge clk);
        expect_store("R9 power-fail store");
        chk(!rd_en, "R9 read blocked while off", rd_en, 0);
        supply_ok = 1'b1; @(negedge clk);
        expect_recall("R2 recall on supply return");

        // R10: auto-store disabled
        sw_auto_off = 1'b1; @(negedge clk); sw_auto_off = 1'b0;
        do_write();
        supply_ok = 1'b0;
        expect_none(10, "R10 disabled power-fail store");
        supply_ok = 1'b1; @(negedge clk);
        expect_recall("R2 recall after disabled drop");

        // R11: recall cleared the flag, so a line request does nothing
        hw_req_n = 1'b0;
        expect_none(GC + 6, "R11 recall clears written flag");
        hw_req_n = 1'b1; @(negedge clk);

        // R10: re-enabled power-fail store
        sw_auto_on = 1'b1; @(negedge clk); sw_auto_on = 1'b0;
        do_write();
        supply_ok = 1'b0; @(negedge clk);
        expect_store("R10 re-enabled power-fail store");
        supply_ok = 1'b1; @(negedge clk);
        expect_recall("R2 recall after store");

        // R9: clean supply drop does no store
        supply_ok = 1'b0;
        expect_none(8, "R9 clean drop no store");
        supply_ok = 1'b1; @(negedge clk);
        wait_go(3, hit, cnt);
        chk(hit, "R2 final recall", hit, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule